// File: doc/BRIEF.md
# Serial ADC Master Interface

This block is a master-only synchronous serial port that sets up and reads an external analog-to-digital converter. It is controlled through one 32-bit data register. A write to the register, accepted while the port is idle, holds both a configuration word for the converter and the total length of the serial frame, counted in shift clocks. The frame covers the configuration bits, any null bits and the result bits.

An accepted write starts the transfer. First a synchronisation pulse lasts one shift-clock period. Then the shift clock runs for the programmed number of periods. The configuration bits go out MSB first, and the converter's data line is sampled on the selected shift-clock edge into a 16-bit receive register. A busy flag covers the whole transfer. An end-of-transfer interrupt rises when the transfer ends and stays high until the register is read.

A mode input selects how the written word is laid out. In the default layout a fixed 8-bit configuration byte is sent. In the extended layout the number of configuration bits, from 8 to 16, is itself a field of the word. The shift-clock rate comes from a divider input.

Top module: `adc_serial_master`

## Requirements
- R1: Default layout (`ext_mode`=0): bits 7:0 are an 8-bit configuration byte, sent MSB first (bit 7 in the first shift period). Bits 12:8 are the frame length. All other bits of the write are ignored.
- R2: Extended layout (`ext_mode`=1): bits 6:0 give the configuration length N. Values below 8 are taken as 8 and values above 16 as 16. The sent bits are bits 16+N-1 down to 16, MSB first. Bits 12:7 are a 6-bit frame length. Bits 31:16 above the first N are ignored.
- R3: After the sync period, `sclk` makes exactly frame-length high pulses. A frame length of zero gives no pulses, and the transfer ends after the sync period.
- R4: Each half of a shift-clock period lasts `clk_div` system cycles, and values below 2 count as 2. `sync` rises on the edge that accepts the write and stays high for one full period (2×`clk_div` cycles) while `sclk` stays low. `sclk` idles low.
- R5: With `fall_sample`=0, `sdi` is sampled at each rising `sclk` edge. With `fall_sample`=1, it is sampled at each falling edge.
- R6: `rd_data` is {16'b0, receive register}. The receive register is cleared when a transfer starts. Each sample shifts in at bit 0, so after a transfer the register holds the last 16 samples, with the earliest in bit 15.
- R7: `busy` is high from the edge that accepts the write until the edge of the last falling `sclk` edge, or the end of the sync period for a zero-length frame. `eot_irq` rises on the same edge that `busy` falls.
- R8: A one-cycle `rd_en` clears `eot_irq`. The interrupt never sets except at the end of a transfer.
- R9: A write while `busy` is high is ignored, and the running transfer finishes with its own configuration.
- R10: `sdo` is low when idle, during the sync period, and in every shift period after the configuration bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 32 | Write data: configuration and frame length |
| rd_en | input | 1 | Read strobe; clears the interrupt |
| rd_data | output | 32 | Received data, upper half zero |
| ext_mode | input | 1 | 0 selects the default layout, 1 the extended layout |
| fall_sample | input | 1 | 1 samples `sdi` on the falling `sclk` edge |
| clk_div | input | 8 | Half-period of the shift clock in system cycles |
| sclk | output | 1 | Shift clock to the converter |
| sync | output | 1 | Frame synchronisation pulse |
| sdo | output | 1 | Serial configuration data to the converter |
| sdi | input | 1 | Serial result data from the converter |
| busy | output | 1 | Transfer in progress |
| eot_irq | output | 1 | End-of-transfer interrupt |

## Verification
The assertions assume that `clk_div`, `ext_mode` and `fall_sample` stay constant for the length of a transfer. They also assume `clk_div` is at least 2 whenever the shift-clock width is relied on. The bench sets all three before each write and changes them only once `busy` has fallen. The converter model changes `sdi` only on the `sclk` edge opposite to the sampling edge, so every sample sees a settled value. The one deliberate write during a transfer goes in while `sclk` is low in the first shift period.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    localparam int WORD_W   = 32;
    localparam int CFG_W    = 16;
    localparam int LEN_W    = 5;
    localparam int FRAME_W  = 6;
    localparam int RX_W     = 16;
    localparam int MIN_BITS = 8;
    localparam int MAX_BITS = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2
    } ser_state_e;

    typedef struct packed {
        logic [CFG_W-1:0]   tx_word;   // left-aligned, first bit in MSB
        logic [LEN_W-1:0]   tx_len;    // number of configuration bits
        logic [FRAME_W-1:0] frame_len; // shift clocks after sync
    } xfer_cfg_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [6:0] raw);
        logic [LEN_W-1:0] n;
        if (raw < 7'(MIN_BITS))      n = LEN_W'(MIN_BITS);
        else if (raw > 7'(MAX_BITS)) n = LEN_W'(MAX_BITS);
        else                         n = raw[LEN_W-1:0];
        return n;
    endfunction

    function automatic xfer_cfg_t decode_cfg(input logic [WORD_W-1:0] w,
                                             input logic ext);
        xfer_cfg_t c;
        logic [LEN_W-1:0] n;
        if (ext) begin
            n           = clamp_len(w[6:0]);
            c.tx_word   = w[31:16] << (LEN_W'(CFG_W) - n);
            c.tx_len    = n;
            c.frame_len = w[12:7];
        end else begin
            c.tx_word   = {w[7:0], 8'h00};
            c.tx_len    = LEN_W'(MIN_BITS);
            c.frame_len = {1'b0, w[12:8]};
        end
        return c;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff_div;

    always_comb begin
        eff_div = (div < MIN_DIV) ? MIN_DIV : div;
        tick    = run && (cnt == eff_div - DIV_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_len,
    input  logic               tick,
    input  logic               fall_sample,
    output ser_state_e         state,
    output logic               half_hi,
    output logic [FRAME_W-1:0] bit_idx,
    output logic               sample,
    output logic               done
);
    logic last_bit;

    always_comb begin
        last_bit = (bit_idx == frame_len - FRAME_W'(1));
        sample   = (state == ST_SHIFT) && tick && (half_hi == fall_sample);
        done     = tick && half_hi &&
                   (((state == ST_SYNC)  && (frame_len == '0)) ||
                    ((state == ST_SHIFT) && last_bit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            half_hi <= 1'b0;
            bit_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_SYNC;
                        half_hi <= 1'b0;
                        bit_idx <= '0;
                    end
                end
                ST_SYNC: begin
                    if (tick) begin
                        half_hi <= !half_hi;
                        if (half_hi)
                            state <= (frame_len == '0) ? ST_IDLE : ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        half_hi <= !half_hi;
                        if (half_hi) begin
                            if (last_bit) state <= ST_IDLE;
                            else          bit_idx <= bit_idx + FRAME_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_shift_path.sv
module adc_shift_path
    import adc_ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               shifting,
    input  xfer_cfg_t          cfg,
    input  logic [FRAME_W-1:0] bit_idx,
    input  logic               sample,
    input  logic               sdi,
    output logic               sdo,
    output logic [RX_W-1:0]    rx_data
);
    logic [3:0] tx_sel;

    always_comb begin
        tx_sel = 4'(CFG_W - 1) - bit_idx[3:0];
        sdo    = shifting && (bit_idx < FRAME_W'(cfg.tx_len)) && cfg.tx_word[tx_sel];
    end

    always_ff @(posedge clk) begin
        if (rst || start) rx_data <= '0;
        else if (sample)  rx_data <= {rx_data[RX_W-2:0], sdi};
    end
endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master
    import adc_ser_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    output logic [31:0]      rd_data,
    input  logic             ext_mode,
    input  logic             fall_sample,
    input  logic [DIV_W-1:0] clk_div,
    output logic             sclk,
    output logic             sync,
    output logic             sdo,
    input  logic             sdi,
    output logic             busy,
    output logic             eot_irq
);
    ser_state_e         state;
    xfer_cfg_t          cfg;
    logic               start, tick, half_hi, sample, done, shifting;
    logic [FRAME_W-1:0] bit_idx;
    logic [RX_W-1:0]    rx_data;

    assign busy     = (state != ST_IDLE);
    assign start    = wr_en && !busy;
    assign shifting = (state == ST_SHIFT);
    assign sclk     = shifting && half_hi;
    assign sync     = (state == ST_SYNC);
    assign rd_data  = {{(WORD_W-RX_W){1'b0}}, rx_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            eot_irq <= 1'b0;
        end else begin
            if (start)      cfg <= decode_cfg(wr_data, ext_mode);
            if (done)       eot_irq <= 1'b1;
            else if (rd_en) eot_irq <= 1'b0;
        end
    end

    adc_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .run(busy), .div(clk_div), .tick(tick)
    );

    adc_frame_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .frame_len(cfg.frame_len),
        .tick(tick), .fall_sample(fall_sample), .state(state),
        .half_hi(half_hi), .bit_idx(bit_idx), .sample(sample), .done(done)
    );

    adc_shift_path u_path (
        .clk(clk), .rst(rst), .start(start), .shifting(shifting), .cfg(cfg),
        .bit_idx(bit_idx), .sample(sample), .sdi(sdi), .sdo(sdo),
        .rx_data(rx_data)
    );
endmodule

module adc_serial_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic        sclk,
    input logic        sync,
    input logic        sdo,
    input logic        busy,
    input logic        eot_irq
);
    // R4
    sync_sclk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sync && sclk));
    // R4
    start_sync_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> sync);
    // R4
    sclk_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |=> sclk);
    // R10
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy || sync) |-> !sdo);
    // R7
    irq_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> eot_irq);
    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eot_irq) |-> $fell(busy));
    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !busy) |=> !eot_irq);
    // R9
    busy_write_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && !sync) |=> !sync);
    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:16] == 16'h0000);
endmodule

bind adc_serial_master adc_serial_master_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .sclk(sclk), .sync(sync), .sdo(sdo), .busy(busy), .eot_irq(eot_irq)
);

// File: tb/adc_serial_master_test.sv
module adc_serial_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        ext_mode = 1'b0;
    logic        fall_sample = 1'b0;
    logic [7:0]  clk_div = 8'd2;
    logic        sclk, sync, sdo, busy, eot_irq;
    logic        sdi = 1'b0;

    int tests = 0;
    int fails = 0;
    int rises = 0;

    always #5 clk = ~clk;
    always @(posedge sclk) rises++;

    adc_serial_master uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .ext_mode(ext_mode), .fall_sample(fall_sample),
        .clk_div(clk_div), .sclk(sclk), .sync(sync), .sdo(sdo), .sdi(sdi),
        .busy(busy), .eot_irq(eot_irq)
    );

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int frame_of(input logic [31:0] w, input logic ext);
        return ext ? int'(w[12:7]) : int'(w[12:8]);
    endfunction

    function automatic logic tx_bit(input logic [31:0] w, input logic ext, input int i);
        int n;
        if (!ext) return (i < 8) ? w[7-i] : 1'b0;
        n = int'(w[6:0]);
        if (n < 8)  n = 8;
        if (n > 16) n = 16;
        return (i < n) ? w[16+n-1-i] : 1'b0;
    endfunction

    // one complete transfer; poke issues a second write during the first period
    task automatic run_xfer(input string tag, input logic [31:0] w, input logic ext,
                            input logic fall, input logic [7:0] div,
                            input logic [63:0] pat, input logic poke);
        int frame, cnt, base, eff, txerr;
        logic [15:0] exp_rx;
        frame = frame_of(w, ext);
        eff = (div < 2) ? 2 : int'(div);
        @(negedge clk);
        ext_mode = ext; fall_sample = fall; clk_div = div; wr_data = w; wr_en = 1'b1;
        base = rises;
        @(negedge clk);
        wr_en = 1'b0;
        check({tag, " R7 busy after write"}, busy, 1);
        cnt = 0;
        while (sync && cnt < 1000) begin cnt++; @(negedge clk); end
        check({tag, " R4 sync length"}, cnt, 2 * eff);
        if (poke) begin
            wr_data = 32'h0000_0F81; ext_mode = 1'b1; wr_en = 1'b1;
            @(negedge clk);
            wr_en = 1'b0; ext_mode = ext;
        end
        txerr = 0;
        exp_rx = '0;
        for (int i = 0; i < frame; i++) begin
            if (!fall) sdi = pat[i];
            @(posedge sclk);
            #1;
            if (sdo !== tx_bit(w, ext, i)) txerr++;
            if (fall) sdi = pat[i];
            exp_rx = {exp_rx[14:0], pat[i]};
            @(negedge sclk);
        end
        cnt = 0;
        while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
        @(negedge clk);
        check({tag, " R1 R2 R10 sdo bits"}, txerr, 0);
        check({tag, " R3 sclk pulses"}, rises - base, frame);
        check({tag, " R7 busy low at end"}, busy, 0);
        check({tag, " R7 irq set"}, eot_irq, 1);
        check({tag, " R5 R6 rd_data"}, rd_data, {16'h0, exp_rx});
        check({tag, " R10 sdo idle"}, sdo, 0);
    endtask

    task automatic do_read(input string tag);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check({tag, " R8 irq cleared"}, eot_irq, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("reset busy", busy, 0);
        check("reset R4 sclk", sclk, 0);
        check("reset R4 sync", sync, 0);
        check("reset R10 sdo", sdo, 0);
        check("reset R8 irq", eot_irq, 0);
        check("reset R6 rd_data", rd_data, 0);
    endtask

    task automatic t_default();
        // R1: byte A5, frame 25, junk in upper bits ignored
        run_xfer("dflt", 32'hFFFF_B9A5, 1'b0, 1'b0, 8'd2, 64'h0_0001_6C3A_5, 1'b0);
        do_read("dflt");
    endtask

    task automatic t_ext_fall();
        // R2 R5: 10 config bits, frame 23, falling edge sample
        run_xfer("ext10", {16'hF2D7, 3'b000, 6'd23, 7'd10}, 1'b1, 1'b1, 8'd3,
                 64'h0_0055_3C91, 1'b0);
        do_read("ext10");
    endtask

    task automatic t_ext_full();
        // R2 R3: 16 bits, frame 33
        run_xfer("ext16", {16'h8E31, 3'b000, 6'd33, 7'd16}, 1'b1, 1'b0, 8'd2,
                 64'h1_A5C3_0F96, 1'b0);
        run_xfer("clamp_lo", {16'h00C6, 3'b000, 6'd12, 7'd3}, 1'b1, 1'b0, 8'd2,
                 64'h0000_0F0F, 1'b0);
        run_xfer("clamp_hi", {16'hBEEF, 3'b000, 6'd20, 7'd40}, 1'b1, 1'b1, 8'd2,
                 64'h0009_3333, 1'b0);
        do_read("clamp");
    endtask

    task automatic t_zero_frame();
        // R3: zero length frame, R4: divider below 2 acts as 2
        run_xfer("zero", 32'h0000_00FF, 1'b0, 1'b0, 8'd0, 64'h0, 1'b0);
        do_read("zero");
    endtask

    task automatic t_busy_write();
        // R9: second write during transfer has no effect
        run_xfer("busywr", 32'h0000_1C3C, 1'b0, 1'b1, 8'd3, 64'h0_0000_7E81, 1'b1);
        do_read("busywr");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_default();
                t_ext_fall();
                t_ext_full();
                t_zero_frame();
                t_busy_write();
            end
            begin
                repeat (150000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule